// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block is a passive observer that sits beside an SDRAM command bus and checks it. On every rising clock edge it samples four active-low command lines and the bank address. It decodes each cycle into one command class and keeps an open/closed flag for every bank. It reports any cycle that breaks the ordering rules of the bus. It never drives the bus.

A detected violation raises a one-cycle error strobe. It also loads a sticky error code, which holds the first violation seen until software-style logic or a test harness pulses the clear input. Four saturating counters record how many Activate, Read, Write and Precharge commands were accepted. The per-bank open flags are brought out as a vector, so that the tracked state can be observed directly. Every output is registered and reflects the command sampled at the most recent rising edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Pins are read as {cs_n, ras_n, cas_n, we_n}. 0011 decodes as Activate, 0101 as Read, 0100 as Write and 0010 as Precharge. Each accepted command increments its own counter, visible after the sampling edge.
- R2: A cycle with cs_n=1 is a Deselect. It changes no bank flag, no counter and no error output, whatever the other pins carry.
- R3: Activate sets bank_open[ba] after the sampling edge.
- R4: Precharge clears bank_open[ba]. A Precharge to a bank that is already closed is legal and raises no error.
- R5: A Read to a closed bank is an error with code 1. A Write to a closed bank is an error with code 2.
- R6: Reads and Writes to an open bank, in any order, raise no error.
- R7: An Activate to a bank that is already open is an error with code 3, and the bank stays open.
- R8: A Write sampled on the cycle directly after a Write is an error with code 4. Any non-Write cycle in between, such as a Deselect or a NOP, avoids it. A Write to a closed bank reports code 2 in preference to code 4.
- R9: err_pulse is high for exactly the one cycle after each violating command. err_code keeps the first nonzero code until clr_err is sampled high. If a violation and clr_err fall on the same cycle, the new code is loaded.
- R10: Each counter stops at its all-ones value and does not wrap.
- R11: A synchronous active-high reset clears all bank flags, all counters, err_pulse and err_code.
- R12: NOP (0111) and the unused patterns with cs_n=0 change no bank flag, no counter and no error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory command clock; sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Clears the sticky error code |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| bank_open | output | 2**BA_W | One open-row flag per bank |
| err_pulse | output | 1 | One-cycle violation strobe |
| err_code | output | 3 | Sticky code of the first violation |
| act_cnt | output | CNT_W | Activate count |
| rd_cnt | output | CNT_W | Read count |
| wr_cnt | output | CNT_W | Write count |
| pre_cnt | output | CNT_W | Precharge count |

## Verification
A wrong bank flag shows up on bank_open one cycle after the command that set or cleared it. It also shows up as a missing or spurious err_pulse on the next access to that bank, so the bench checks both views after every command. A stale previous-Write flag only becomes visible when a second Write arrives. For that reason the bench separates Writes with Deselect, with NOP and with nothing at all. Counter and sticky-code faults appear immediately after the sampling edge. Saturation is driven past the all-ones value with a narrow counter width.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;
  typedef enum logic [2:0] {
    C_DESEL, C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_OTHER
  } cmd_e;

  typedef enum logic [2:0] {
    E_NONE      = 3'd0,
    E_RD_CLOSED = 3'd1,
    E_WR_CLOSED = 3'd2,
    E_ACT_OPEN  = 3'd3,
    E_WR_WR     = 3'd4
  } err_e;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);
  always_comb begin
    if (cs_n) cmd = C_DESEL;
    else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = C_ACT;
        3'b101:  cmd = C_RD;
        3'b100:  cmd = C_WR;
        3'b010:  cmd = C_PRE;
        3'b111:  cmd = C_NOP;
        default: cmd = C_OTHER;
      endcase
    end
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int BA_W  = 3,
  localparam int NBANK = 1 << BA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_e             cmd,
  input  logic [BA_W-1:0]  ba,
  output logic [NBANK-1:0] bank_open
);
  always_ff @(posedge clk) begin
    if (rst) bank_open <= '0;
    else if (cmd == C_ACT) bank_open[ba] <= 1'b1;
    else if (cmd == C_PRE) bank_open[ba] <= 1'b0;
  end

  // R3
  act_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_ACT) |=> bank_open[$past(ba)]);
  // R4
  pre_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_PRE) |=> !bank_open[$past(ba)]);
  // R2
  desel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_DESEL) |=> $stable(bank_open));
endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       clr_err,
  input  cmd_e       cmd,
  input  logic       hit_open,
  output logic       err_pulse,
  output logic [2:0] err_code
);
  logic prev_wr;
  err_e now_err;

  always_comb begin
    now_err = E_NONE;
    unique case (cmd)
      C_RD:  if (!hit_open) now_err = E_RD_CLOSED;
      C_WR:  if (!hit_open) now_err = E_WR_CLOSED;
             else if (prev_wr) now_err = E_WR_WR;
      C_ACT: if (hit_open) now_err = E_ACT_OPEN;
      default: now_err = E_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_wr   <= 1'b0;
      err_pulse <= 1'b0;
      err_code  <= 3'd0;
    end else begin
      prev_wr   <= (cmd == C_WR);
      err_pulse <= (now_err != E_NONE);
      if (now_err != E_NONE && (err_code == 3'd0 || clr_err))
        err_code <= now_err;
      else if (clr_err)
        err_code <= 3'd0;
    end
  end

  // R9
  pulse_code_chk: assert property (@(posedge clk) disable iff (rst)
    err_pulse |-> (err_code != 3'd0));
  // R9
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ((err_code != 3'd0) && !clr_err) |=> $stable(err_code));
  // R12
  nop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_NOP || cmd == C_OTHER || cmd == C_DESEL) |=> !err_pulse);
endmodule

// File: rtl/sdram_sat_counter.sv
module sdram_sat_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && cnt != MAXV) cnt <= cnt + 1'b1;
  end

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXV) |=> (cnt == MAXV));
  // R1
  step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && cnt != MAXV) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W  = 3,
  parameter int CNT_W = 16,
  localparam int NBANK = 1 << BA_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_err,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  output logic [NBANK-1:0] bank_open,
  output logic             err_pulse,
  output logic [2:0]       err_code,
  output logic [CNT_W-1:0] act_cnt,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [CNT_W-1:0] wr_cnt,
  output logic [CNT_W-1:0] pre_cnt
);
  cmd_e cmd;
  logic [CNT_W-1:0] cnts [4];
  cmd_e cnt_sel [4];

  assign cnt_sel[0] = C_ACT;
  assign cnt_sel[1] = C_RD;
  assign cnt_sel[2] = C_WR;
  assign cnt_sel[3] = C_PRE;

  sdram_cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
  );

  sdram_bank_track #(.BA_W(BA_W)) u_banks (
    .clk(clk), .rst(rst), .cmd(cmd), .ba(ba), .bank_open(bank_open)
  );

  sdram_rule_check u_rules (
    .clk(clk), .rst(rst), .clr_err(clr_err), .cmd(cmd),
    .hit_open(bank_open[ba]), .err_pulse(err_pulse), .err_code(err_code)
  );

  for (genvar i = 0; i < 4; i++) begin : g_cnt
    sdram_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(cmd == cnt_sel[i]), .cnt(cnts[i])
    );
  end

  assign act_cnt = cnts[0];
  assign rd_cnt  = cnts[1];
  assign wr_cnt  = cnts[2];
  assign pre_cnt = cnts[3];

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (bank_open == '0 && !err_pulse && err_code == 3'd0 && act_cnt == '0));
endmodule

// File: tb/sdram_cmd_monitor_test.sv
module sdram_cmd_monitor_test;
  localparam int BA_W  = 3;
  localparam int CNT_W = 4;
  localparam logic [3:0] P_ACT = 4'b0011, P_RD = 4'b0101, P_WR = 4'b0100,
                         P_PRE = 4'b0010, P_NOP = 4'b0111, P_DES = 4'b1111;

  logic clk = 1'b0, rst = 1'b1, clr_err = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [BA_W-1:0] ba = '0;
  logic [7:0] bank_open;
  logic err_pulse;
  logic [2:0] err_code;
  logic [CNT_W-1:0] act_cnt, rd_cnt, wr_cnt, pre_cnt;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(.BA_W(BA_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .clr_err(clr_err), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .bank_open(bank_open),
    .err_pulse(err_pulse), .err_code(err_code), .act_cnt(act_cnt),
    .rd_cnt(rd_cnt), .wr_cnt(wr_cnt), .pre_cnt(pre_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] p, input int b, input bit clr = 1'b0);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = p;
    ba = b[BA_W-1:0];
    clr_err = clr;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    {cs_n, ras_n, cas_n, we_n} = P_DES;
    clr_err = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    issue(P_ACT, 1); issue(P_RD, 5);
    do_reset();
    chk("R11 bank_open", bank_open, 0);
    chk("R11 err_code", err_code, 0);
    chk("R11 err_pulse", err_pulse, 0);
    chk("R11 counters", act_cnt + rd_cnt + wr_cnt + pre_cnt, 0);
  endtask

  task automatic t_open_close();
    do_reset();
    issue(P_ACT, 2);
    chk("R3 act opens", bank_open, 8'h04);
    chk("R1 act_cnt", act_cnt, 1);
    issue(P_RD, 2); chk("R6 rd open", err_pulse, 0);
    issue(P_WR, 2); chk("R6 wr after rd", err_pulse, 0);
    issue(P_RD, 2); chk("R6 rd after wr", err_pulse, 0);
    chk("R1 rd_cnt", rd_cnt, 2);
    chk("R1 wr_cnt", wr_cnt, 1);
    issue(P_PRE, 2);
    chk("R4 pre closes", bank_open, 0);
    issue(P_PRE, 5);
    chk("R4 pre idle no err", err_pulse, 0);
    chk("R4 err_code", err_code, 0);
    chk("R1 pre_cnt", pre_cnt, 2);
  endtask

  task automatic t_closed_access();
    do_reset();
    issue(P_RD, 3);
    chk("R5 rd closed pulse", err_pulse, 1);
    chk("R5 rd closed code", err_code, 1);
    issue(P_DES, 0);
    chk("R9 pulse one cycle", err_pulse, 0);
    chk("R9 sticky", err_code, 1);
    issue(P_WR, 4);
    chk("R9 pulse again", err_pulse, 1);
    chk("R9 first kept", err_code, 1);
    issue(P_DES, 0, 1'b1);
    chk("R9 clear", err_code, 0);
    issue(P_WR, 4);
    chk("R5 wr closed code", err_code, 2);
    issue(P_RD, 6, 1'b1);
    chk("R9 err wins over clr", err_code, 1);
  endtask

  task automatic t_act_open();
    do_reset();
    issue(P_ACT, 1); issue(P_ACT, 1);
    chk("R7 code", err_code, 3);
    chk("R7 stays open", bank_open, 8'h02);
    chk("R7 act_cnt", act_cnt, 2);
  endtask

  task automatic t_wr_wr();
    do_reset();
    issue(P_ACT, 0);
    issue(P_WR, 0); issue(P_WR, 0);
    chk("R8 wr wr pulse", err_pulse, 1);
    chk("R8 wr wr code", err_code, 4);
    issue(P_DES, 0, 1'b1);
    issue(P_WR, 0); issue(P_DES, 0); issue(P_WR, 0);
    chk("R8 desel between", err_code, 0);
    issue(P_NOP, 0); issue(P_WR, 0);
    chk("R8 nop between", err_code, 0);
    issue(P_WR, 6);
    chk("R8 closed wins", err_code, 2);
  endtask

  task automatic t_ignored();
    do_reset();
    issue(P_ACT, 3);
    issue(4'b1011, 3); issue(4'b1010, 3); issue(4'b1101, 5);
    chk("R2 desel banks", bank_open, 8'h08);
    chk("R2 desel counts", act_cnt + rd_cnt + wr_cnt + pre_cnt, 1);
    chk("R2 desel no err", err_code, 0);
    issue(P_NOP, 3); issue(4'b0000, 3); issue(4'b0110, 2); issue(4'b0001, 4);
    chk("R12 banks", bank_open, 8'h08);
    chk("R12 counts", act_cnt + rd_cnt + wr_cnt + pre_cnt, 1);
    chk("R12 no err", err_code, 0);
  endtask

  task automatic t_saturate();
    do_reset();
    for (int i = 0; i < 20; i++) begin
      issue(P_ACT, 7); issue(P_PRE, 7);
    end
    chk("R10 act sat", act_cnt, 15);
    chk("R10 pre sat", pre_cnt, 15);
    chk("R10 no err", err_code, 0);
  endtask

  initial begin
    t_reset();
    t_open_close();
    t_closed_access();
    t_act_open();
    t_wr_wr();
    t_ignored();
    t_saturate();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule